// File: doc/BRIEF.md
# Refresh Request Queue Arbiter

This block turns a periodic interval tick into DRAM refresh requests and keeps them in a small counting queue. Refresh waits for an idle memory bus. It takes the bus only when no other memory request is pending, unless the queue has filled up. In that case refresh gets top priority and goes ahead of everything else. The refresh is a CAS-before-RAS command issued by a downstream sequencer. That sequencer sees the grant, runs the cycle and answers with a one-cycle completion pulse.

Each refresh goes to one row, taken from a populated-row mask. A rotating pointer walks the populated rows in turn and steps over any row that is not fitted. A control input reduces the queue to a single slot. In that mode a request is not left to accumulate and is serviced as soon as it arrives. A tick that finds no free slot is lost and raises a sticky overflow flag.

Top module: `refresh_queue_arbiter`

## Requirements
- R1: Queue occupancy `occupancy_o` counts accepted ticks minus completed refreshes, starts at 0 after reset and never exceeds DEPTH (default 4).
- R2: While `queue_dis_i` is 1 the capacity is one entry: one pending request is already high priority and is granted at once, even with `other_req_i` at 1. A further tick while that entry is held, with no completion in the same cycle, is dropped.
- R3: Below capacity, a new grant starts only in a cycle where `other_req_i` is 0 and the occupancy is nonzero.
- R4: When the occupancy reaches the capacity (DEPTH, or 1 when disabled), `high_prio_o` is 1 and a grant is issued in that cycle regardless of `other_req_i`, provided a populated row exists.
- R5: `row_o` is always a row whose bit in `row_populated_i` is 1 whenever that mask is nonzero. Unpopulated rows are never selected.
- R6: A `refresh_done_i` pulse while `grant_o` is 1 lowers the occupancy by one. A pulse without a grant is ignored, and the occupancy never wraps below 0.
- R7: A tick is accepted when the occupancy, after that cycle's completion, is below capacity. Otherwise the tick is dropped and `overflow_o` is set and stays 1 until reset.
- R8: After each completed refresh the row pointer moves to the row after the one refreshed. The next grant uses the first populated row at or after it, wrapping from the top row to row 0.
- R9: With `row_populated_i` all zero no new grant is issued, while ticks are still counted.
- R10: Once `grant_o` rises it stays 1 in every following cycle until `refresh_done_i` is seen. The grant comes from the pending queue and `other_req_i` in the same cycle, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle refresh interval tick |
| other_req_i | input | 1 | Another memory request is pending |
| queue_dis_i | input | 1 | 1 reduces the queue to a single entry |
| row_populated_i | input | NROWS (8) | Bit n set when row n is fitted |
| refresh_done_i | input | 1 | Refresh cycle completed (one-cycle pulse) |
| grant_o | output | 1 | Refresh owns the memory bus |
| high_prio_o | output | 1 | Queue at capacity, refresh outranks others |
| row_o | output | clog2(NROWS) (3) | Row to refresh |
| occupancy_o | output | clog2(DEPTH+1) (3) | Pending refresh count |
| overflow_o | output | 1 | Sticky: a tick was dropped |

## Verification
The bench fills the queue while other traffic is pending, to confirm escalation at exactly four entries. A design that escalated early would steal bus cycles, and one that escalated late would starve refresh. A fifth tick on a full queue, and a completion pulse with no grant, check that the count neither wraps nor underflows and that overflow latches. Rows are taken from a sparse mask so the pointer must skip holes and wrap from the top. An arbiter that only incremented the pointer would refresh absent rows. The single-entry mode and the all-zero mask are forced directly. Random traffic is then compared cycle by cycle with a reference model, which catches a grant that drops before completion.

// File: rtl/rqa_pkg.sv
package rqa_pkg;
   typedef enum logic {
      ARB_IDLE = 1'b0,
      ARB_BUSY = 1'b1
   } arb_state_e;
endpackage

// File: rtl/rqa_occupancy.sv
module rqa_occupancy #(
   parameter int DEPTH = 4,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             done_ok_i,
   input  logic             queue_dis_i,
   output logic [CNT_W-1:0] occ_o,
   output logic             pending_o,
   output logic             high_o,
   output logic             ovf_o
);
   localparam logic [CNT_W-1:0] CAP_FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] CAP_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d, base, cap;
   logic             accept, drop, ovf_q;

   always_comb begin
      cap    = queue_dis_i ? CAP_ONE : CAP_FULL;
      base   = (done_ok_i && cnt_q != '0) ? cnt_q - CNT_W'(1) : cnt_q;
      accept = tick_i && (base < cap);
      drop   = tick_i && !accept;
      cnt_d  = accept ? base + CNT_W'(1) : base;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (drop) ovf_q <= 1'b1;
      end
   end

   assign occ_o     = cnt_q;
   assign pending_o = (cnt_q != '0);
   assign high_o    = (cnt_q != '0) && (cnt_q >= cap);
   assign ovf_o     = ovf_q;

   AST_OCC_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CAP_FULL); // R1
   AST_DIS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (queue_dis_i && cnt_q <= CAP_ONE) |=> (cnt_q <= CAP_ONE)); // R2
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !tick_i) |=> (cnt_q == '0)); // R6
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q); // R7
endmodule

// File: rtl/rqa_row_pick.sv
module rqa_row_pick #(
   parameter int NROWS = 8,
   parameter int ROW_W = $clog2(NROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NROWS-1:0] mask_i,
   input  logic             advance_i,
   output logic [ROW_W-1:0] row_o,
   output logic             any_o
);
   localparam int SUM_W = ROW_W + 1;
   localparam logic [SUM_W-1:0] ROWS_S = SUM_W'(NROWS);
   localparam logic [ROW_W-1:0] TOP_ROW = ROW_W'(NROWS - 1);

   logic [ROW_W-1:0] ptr_q;
   logic [ROW_W-1:0] cand [NROWS];
   logic [ROW_W-1:0] sel;
   logic             found;

   for (genvar k = 0; k < NROWS; k++) begin : g_cand
      logic [SUM_W-1:0] sum;
      assign sum     = {1'b0, ptr_q} + SUM_W'(k);
      assign cand[k] = (sum >= ROWS_S) ? ROW_W'(sum - ROWS_S) : ROW_W'(sum);
   end

   always_comb begin
      sel   = ptr_q;
      found = 1'b0;
      for (int k = 0; k < NROWS; k++) begin
         if (!found && mask_i[cand[k]]) begin
            sel   = cand[k];
            found = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         ptr_q <= '0;
      else if (advance_i) ptr_q <= (sel == TOP_ROW) ? '0 : sel + ROW_W'(1);
   end

   assign row_o = sel;
   assign any_o = |mask_i;

   AST_ROW_POPULATED: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> mask_i[row_o]); // R5
endmodule

// File: rtl/rqa_grant.sv
module rqa_grant
   import rqa_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pending_i,
   input  logic high_i,
   input  logic any_i,
   input  logic other_i,
   input  logic done_i,
   output logic grant_o,
   output logic done_ok_o
);
   arb_state_e state_q, state_d;
   logic       start;

   always_comb begin
      start     = (state_q == ARB_IDLE) && pending_i && any_i && (high_i || !other_i);
      grant_o   = (state_q == ARB_BUSY) || start;
      done_ok_o = done_i && grant_o;
      state_d   = (grant_o && !done_ok_o) ? ARB_BUSY : ARB_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ARB_IDLE;
      else        state_q <= state_d;
   end

   AST_HP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (high_i && any_i && pending_i) |-> grant_o); // R4
   AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && !done_i) |=> grant_o); // R10
endmodule

// File: rtl/refresh_queue_arbiter.sv
module refresh_queue_arbiter #(
   parameter int DEPTH = 4,
   parameter int NROWS = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int ROW_W = $clog2(NROWS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             other_req_i,
   input  logic             queue_dis_i,
   input  logic [NROWS-1:0] row_populated_i,
   input  logic             refresh_done_i,
   output logic             grant_o,
   output logic             high_prio_o,
   output logic [ROW_W-1:0] row_o,
   output logic [CNT_W-1:0] occupancy_o,
   output logic             overflow_o
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("refresh_queue_arbiter: DEPTH must be at least 1");
   end
   if (NROWS < 2) begin : g_bad_rows
      $error("refresh_queue_arbiter: NROWS must be at least 2");
   end

   logic pending, high, any_row, done_ok;

   rqa_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .done_ok_i  (done_ok),
      .queue_dis_i(queue_dis_i),
      .occ_o      (occupancy_o),
      .pending_o  (pending),
      .high_o     (high),
      .ovf_o      (overflow_o)
   );

   rqa_row_pick #(.NROWS(NROWS), .ROW_W(ROW_W)) u_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .mask_i   (row_populated_i),
      .advance_i(done_ok),
      .row_o    (row_o),
      .any_o    (any_row)
   );

   rqa_grant u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .pending_i(pending),
      .high_i   (high),
      .any_i    (any_row),
      .other_i  (other_req_i),
      .done_i   (refresh_done_i),
      .grant_o  (grant_o),
      .done_ok_o(done_ok)
   );

   assign high_prio_o = high;

   AST_YIELD_TO_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o && !$past(grant_o) && !high_prio_o) |-> !other_req_i); // R3
   AST_NO_ROWS_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      (row_populated_i == '0 && !grant_o) |=> (row_populated_i != '0 || !grant_o)); // R9
endmodule

// File: tb/sim_refresh_queue_arbiter.sv
`timescale 1ns/1ps
module sim_refresh_queue_arbiter;
   localparam int DEPTH = 4;
   localparam int NROWS = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0, other_req_i = 1'b0, queue_dis_i = 1'b0, refresh_done_i = 1'b0;
   logic [7:0] row_populated_i = 8'h00;
   logic       grant_o, high_prio_o, overflow_o;
   logic [2:0] row_o, occupancy_o;

   int n_checks = 0;
   int n_fail   = 0;

   // reference model state
   int m_cnt, m_ptr;
   bit m_busy, m_ovf;
   // values observed in the last step
   bit ob_gnt, ob_hp, ob_ovf;
   int ob_row, ob_occ;

   always #10 clk = ~clk;

   refresh_queue_arbiter #(.DEPTH(DEPTH), .NROWS(NROWS)) u0 (.*);

   initial begin
      #(20 * 150000);
      $display("FAIL watchdog expired");
      n_fail++;
      n_checks++;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int pick_row(input int ptr, input logic [7:0] mask);
      for (int k = 0; k < NROWS; k++) begin
         if (mask[(ptr + k) % NROWS]) return (ptr + k) % NROWS;
      end
      return ptr;
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_ptr = 0; m_busy = 0; m_ovf = 0;
   endtask

   // Called at a negedge: drive, check combinational and state outputs, update model.
   task automatic step(input bit t, input bit o, input bit d, input bit dis, input logic [7:0] mask);
      int  cap, sel, base;
      bit  hp, start, gnt, dok, acc;
      tick_i = t; other_req_i = o; refresh_done_i = d; queue_dis_i = dis; row_populated_i = mask;
      #2;
      cap   = dis ? 1 : DEPTH;
      hp    = (m_cnt > 0) && (m_cnt >= cap);
      start = !m_busy && (m_cnt > 0) && (mask != 0) && (hp || !o);
      gnt   = m_busy || start;
      sel   = pick_row(m_ptr, mask);
      ob_gnt = grant_o; ob_hp = high_prio_o; ob_row = row_o; ob_occ = occupancy_o; ob_ovf = overflow_o;
      chk(grant_o == gnt, "R3 grant", grant_o, gnt);
      chk(high_prio_o == hp, "R4 high_prio", high_prio_o, hp);
      chk(int'(row_o) == sel, "R5 row", row_o, sel);
      chk(int'(occupancy_o) == m_cnt, "R1 occupancy", occupancy_o, m_cnt);
      chk(overflow_o == m_ovf, "R7 overflow", overflow_o, m_ovf);
      dok  = d && gnt;
      base = (dok && m_cnt > 0) ? m_cnt - 1 : m_cnt;
      acc  = t && (base < cap);
      if (t && !acc) m_ovf = 1;
      m_cnt  = base + (acc ? 1 : 0);
      m_busy = gnt && !dok;
      if (dok) m_ptr = (sel + 1) % NROWS;
      @(negedge clk);
   endtask

   initial begin
      logic [7:0] mask;
      bit dis;
      int unsigned seed;
      model_reset();
      @(negedge clk);
      @(negedge clk);
      #2;
      chk(occupancy_o == 0, "R1 reset occupancy", occupancy_o, 0);
      chk(grant_o == 0, "R3 reset grant", grant_o, 0);
      chk(overflow_o == 0, "R7 reset overflow", overflow_o, 0);
      @(negedge clk);
      rst_n = 1'b1;

      mask = 8'b1010_0100; // rows 2, 5, 7
      // fill under constant other traffic: no grant until full
      for (int i = 0; i < 4; i++) step(1, 1, 0, 0, mask);
      step(0, 1, 0, 0, mask);
      chk(ob_occ == 4, "R1 full count", ob_occ, 4);
      chk(ob_hp && ob_gnt, "R4 escalate at four", ob_gnt, 1);
      chk(ob_row == 2, "R5 first populated row", ob_row, 2);
      step(1, 1, 0, 0, mask);           // fifth tick dropped
      step(0, 1, 0, 0, mask);
      chk(ob_ovf && ob_occ == 4, "R7 drop on full", ob_occ, 4);
      step(0, 1, 1, 0, mask);           // complete row 2
      step(0, 1, 0, 0, mask);
      chk(ob_occ == 3, "R6 completion decrements", ob_occ, 3);
      chk(!ob_gnt, "R3 yields to other request", ob_gnt, 0);
      chk(ob_row == 5, "R8 pointer skips to row 5", ob_row, 5);
      step(0, 0, 0, 0, mask);
      chk(ob_gnt, "R3 grant when bus idle", ob_gnt, 1);
      step(0, 1, 0, 0, mask);
      chk(ob_gnt, "R10 grant held until done", ob_gnt, 1);
      step(0, 1, 1, 0, mask);           // complete row 5
      step(0, 0, 1, 0, mask);           // complete row 7
      step(0, 0, 0, 0, mask);
      chk(ob_row == 2, "R8 wrap to row 2", ob_row, 2);
      step(0, 0, 1, 0, mask);           // drain last
      step(0, 0, 1, 0, mask);           // done with no grant
      step(0, 0, 0, 0, mask);
      chk(ob_occ == 0 && !ob_gnt, "R6 no underflow", ob_occ, 0);
      // single-entry mode
      step(1, 1, 0, 1, mask);
      step(1, 1, 0, 1, mask);           // second tick dropped
      chk(ob_gnt && ob_hp, "R2 immediate service", ob_gnt, 1);
      step(0, 1, 0, 1, mask);
      chk(ob_occ == 1, "R2 no accumulation", ob_occ, 1);
      step(0, 1, 1, 1, mask);
      // empty mask
      step(1, 0, 0, 0, 8'h00);
      step(1, 0, 0, 0, 8'h00);
      step(0, 0, 0, 0, 8'h00);
      chk(ob_occ == 2 && !ob_gnt, "R9 count without grant", ob_occ, 2);

      // random phase from clean reset
      rst_n = 1'b0;
      step(0, 0, 0, 0, 8'h00);
      rst_n = 1'b1;
      model_reset();
      seed = 32'd1234;
      void'($urandom(seed));
      dis  = 0;
      mask = 8'b0100_1001;
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(63) == 0) dis = ~dis;
         if ($urandom_range(127) == 0) mask = 8'($urandom_range(255));
         step($urandom_range(5) == 0, $urandom_range(1) == 1,
              $urandom_range(2) == 0, dis, mask);
      end

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule